// File: doc/BRIEF.md
# SIMT Warp Issue Scheduler with Divergence Masking

This block is the issue stage of a small SIMT core. It keeps several warps resident. Each warp has one program counter shared by its 32 lanes and a lane-active mask. Each cycle a round-robin arbiter picks one ready warp and presents that warp's PC and mask as the issue slot. The instruction at that PC comes back in the same cycle as a token. The token either carries no branch or carries a branch with a per-lane take mask, a target PC and a reconvergence PC. The scheduler uses the token to advance the issued warp.

A warp that reports a memory stall is parked, and the arbiter fills the next cycle with another ready warp. A wake event returns the parked warp to the pool one cycle later.

When the active lanes of a branch disagree, the warp runs the taken lanes first. It records the fall-through path on a small per-warp reconvergence stack. When the warp's next PC equals the reconvergence PC on top of the stack, the warp either switches to the pending path or, once both paths are done, pops the entry and restores the union of the two masks.

Each warp's readiness is a two-state machine. `W_RUN` moves to `W_WAIT` on a stall event. `W_WAIT` moves back to `W_RUN` on a wake event with no stall in the same cycle. The scheduler state is `S_ISSUE` when a warp is granted and `S_IDLE` when none is ready. On every issue the warp's reconvergence action is one of:
- `RC_NONE`: plain advance.
- `RC_SWITCH`: jump to the pending path.
- `RC_MERGE`: pop the entry and merge the masks.

Top module: `simt_warp_sched`

## Requirements
- R1: After reset all four warps are in `W_RUN` with PC 0 and mask 32'hFFFF_FFFF. The first grant goes to warp 0, so the issue slot shows warp 0, PC 0, full mask, `issue_valid`=1 and `idle`=0 before the first clock edge.
- R2: The arbiter grants the first ready warp found by searching upward (with wraparound) from the warp after the last one issued. A non-ready warp is never granted.
- R3: `issue_pc` and `issue_mask` are the granted warp's PC and mask. An issued instruction with `br_valid`=0 advances that warp's PC by 1 and leaves its mask unchanged.
- R4: A stall event for warp w in cycle t makes w ineligible from cycle t+1. If another warp is ready, that warp is issued in cycle t+1 with no empty slot.
- R5: A wake event for a waiting warp in cycle t makes it eligible from cycle t+1 and not in cycle t. If stall and wake name the same warp in one cycle, the stall wins.
- R6: When no warp is ready, `idle`=1 and `issue_valid`=0, and no warp state changes through issue.
- R7: For a branch token, lane i of the active mask goes to `br_target` when bit i of `br_take` is 1, and to PC+1 otherwise. If all active lanes agree (uniform branch), the warp follows that single path with its mask unchanged and the stack is not touched.
- R8: On a divergent branch the warp pushes an entry holding the reconvergence PC, PC+1 and the fall-through lanes. It then continues at `br_target` with only the taken lanes active. A divergent branch must not occur when the warp's 4-entry stack is full.
- R9: When an issued warp's next PC equals the top entry's reconvergence PC and the entry's pending path has not yet run, the warp continues at the pending PC with the pending mask.
- R10: When the next PC equals the top entry's reconvergence PC after the pending path has run, the entry is popped. The warp continues at the reconvergence PC with the union of both path masks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Token for the issued instruction is a branch |
| br_take | input | 32 | Per-lane take decision of the branch |
| br_target | input | 16 | Branch target PC |
| br_reconv | input | 16 | Reconvergence PC of the branch |
| stall_valid | input | 1 | Stall event present |
| stall_warp | input | 2 | Warp named by the stall event |
| wake_valid | input | 1 | Wake event present |
| wake_warp | input | 2 | Warp named by the wake event |
| issue_valid | output | 1 | A warp is issued this cycle |
| issue_warp | output | 2 | Issued warp ID |
| issue_pc | output | 16 | PC of the issued warp |
| issue_mask | output | 32 | Lane-active mask of the issued warp |
| idle | output | 1 | No warp is ready |

## Verification
The bench builds the block with its defaults: 4 warps, 32 lanes, 16-bit PCs and a 4-deep stack. With these values it can park every warp and reach the idle state within a handful of cycles. The round-robin pointer can be driven through wraparound and through pairs of ready warps. A half-split mask (lower 16 lanes taken) shows the taken path, the switch to the fall-through path and the merge as distinct mask values on `issue_mask`. The same branch with an all-ones take mask gives the uniform case.

// File: rtl/simt_sched_pkg.sv
package simt_sched_pkg;
    typedef enum logic {
        W_RUN  = 1'b0,
        W_WAIT = 1'b1
    } warp_st_e;

    typedef enum logic {
        S_ISSUE = 1'b0,
        S_IDLE  = 1'b1
    } sched_st_e;

    typedef enum logic [1:0] {
        RC_NONE   = 2'd0,
        RC_SWITCH = 2'd1,
        RC_MERGE  = 2'd2
    } rc_act_e;
endpackage

// File: rtl/reconv_stack.sv
module reconv_stack #(
    parameter int LANES = 32,
    parameter int PC_W  = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PC_W-1:0]  push_rc,
    input  logic [PC_W-1:0]  push_pc,
    input  logic [LANES-1:0] push_mask,
    input  logic             swap,
    input  logic [LANES-1:0] swap_mask,
    input  logic             pop,
    output logic [PC_W-1:0]  top_rc,
    output logic [PC_W-1:0]  top_pc,
    output logic [LANES-1:0] top_mask,
    output logic             top_pend,
    output logic             empty,
    output logic             full
);
    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PC_W-1:0]  rc_q   [DEPTH];
    logic [PC_W-1:0]  pc_q   [DEPTH];
    logic [LANES-1:0] mask_q [DEPTH];
    logic [DEPTH-1:0] pend_q;
    logic [SP_W-1:0]  sp_q;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] top_idx;

    assign wr_idx  = IDX_W'(sp_q);
    assign top_idx = IDX_W'(sp_q - SP_W'(1));
    assign empty   = (sp_q == '0);
    assign full    = (sp_q == SP_W'(DEPTH));

    assign top_rc   = rc_q[top_idx];
    assign top_pc   = pc_q[top_idx];
    assign top_mask = mask_q[top_idx];
    assign top_pend = pend_q[top_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q   <= '0;
            pend_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                rc_q[i]   <= '0;
                pc_q[i]   <= '0;
                mask_q[i] <= '0;
            end
        end else if (push) begin
            rc_q[wr_idx]   <= push_rc;
            pc_q[wr_idx]   <= push_pc;
            mask_q[wr_idx] <= push_mask;
            pend_q[wr_idx] <= 1'b1;
            sp_q           <= sp_q + SP_W'(1);
        end else if (pop) begin
            sp_q <= sp_q - SP_W'(1);
        end else if (swap) begin
            mask_q[top_idx] <= swap_mask;
            pend_q[top_idx] <= 1'b0;
        end
    end

    // R8: a push never lands on a full stack
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R10: a merge only pops a live entry whose pending path already ran
    p_pop_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (!empty && !top_pend));
    // R9: a switch only happens once per entry
    p_swap_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> !top_pend);
endmodule

// File: rtl/warp_arbiter.sv
module warp_arbiter #(
    parameter int NUM_WARPS = 4,
    parameter int ID_W      = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] ready,
    output logic                 grant_valid,
    output logic [ID_W-1:0]      grant_id
);
    logic [ID_W-1:0] last_q;
    logic [ID_W-1:0] cand;

    always_comb begin
        grant_valid = 1'b0;
        grant_id    = '0;
        cand        = '0;
        for (int k = 1; k <= NUM_WARPS; k++) begin
            cand = ID_W'((int'(last_q) + k) % NUM_WARPS);
            if (!grant_valid && ready[cand]) begin
                grant_valid = 1'b1;
                grant_id    = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= ID_W'(NUM_WARPS - 1);
        end else if (grant_valid) begin
            last_q <= grant_id;
        end
    end

    // R2: only a ready warp receives the slot
    p_grant_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ready[grant_id]);
    // R4: any ready warp means the slot is filled
    p_no_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ready) |-> grant_valid);
endmodule

// File: rtl/warp_ctx.sv
module warp_ctx
    import simt_sched_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PC_W  = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_en,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_take,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_reconv,
    input  logic             stall_hit,
    input  logic             wake_hit,
    output logic             ready,
    output logic [PC_W-1:0]  pc,
    output logic [LANES-1:0] mask
);
    warp_st_e         st_q, st_d;
    rc_act_e          rc_act;
    logic [PC_W-1:0]  pc_q, pc_d, seq_pc, path_pc;
    logic [LANES-1:0] mask_q, mask_d, taken, fall;
    logic             diverge, push, swap, pop;
    logic [PC_W-1:0]  top_rc, top_pc;
    logic [LANES-1:0] top_mask;
    logic             top_pend, stk_empty, stk_full;

    // readiness state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= W_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            W_RUN:  if (stall_hit) st_d = W_WAIT;
            W_WAIT: if (wake_hit && !stall_hit) st_d = W_RUN;
        endcase
    end

    assign ready = (st_q == W_RUN);

    // branch resolution and reconvergence
    always_comb begin
        seq_pc  = pc_q + PC_W'(1);
        taken   = mask_q & br_take;
        fall    = mask_q & ~br_take;
        diverge = br_valid && (taken != '0) && (fall != '0);
        path_pc = (br_valid && fall == '0) ? br_target : seq_pc;
        rc_act  = RC_NONE;
        if (!diverge && !stk_empty && path_pc == top_rc) begin
            rc_act = top_pend ? RC_SWITCH : RC_MERGE;
        end
    end

    always_comb begin
        pc_d   = pc_q;
        mask_d = mask_q;
        push   = 1'b0;
        swap   = 1'b0;
        pop    = 1'b0;
        if (issue_en) begin
            if (diverge) begin
                push   = 1'b1;
                pc_d   = br_target;
                mask_d = taken;
            end else begin
                unique case (rc_act)
                    RC_NONE: begin
                        pc_d = path_pc;
                    end
                    RC_SWITCH: begin
                        swap   = 1'b1;
                        pc_d   = top_pc;
                        mask_d = top_mask;
                    end
                    RC_MERGE: begin
                        pop    = 1'b1;
                        pc_d   = path_pc;
                        mask_d = mask_q | top_mask;
                    end
                    default: pc_d = path_pc;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            mask_q <= '1;
        end else begin
            pc_q   <= pc_d;
            mask_q <= mask_d;
        end
    end

    assign pc   = pc_q;
    assign mask = mask_q;

    reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_rc  (br_reconv),
        .push_pc  (seq_pc),
        .push_mask(fall),
        .swap     (swap),
        .swap_mask(mask_q),
        .pop      (pop),
        .top_rc   (top_rc),
        .top_pc   (top_pc),
        .top_mask (top_mask),
        .top_pend (top_pend),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    // R2: a parked warp is never issued
    p_issue_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |-> (st_q == W_RUN));
    // R4: a stall parks the warp in the next cycle
    p_stall_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall_hit |=> !ready);
    // R5: a parked warp stays parked without a wake
    p_wake_needed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !wake_hit) |=> !ready);
    // R3: a warp never runs with every lane masked off
    p_mask_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q != '0);
    // R8: divergence is only legal with room on the stack
    p_push_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_en && diverge) |-> !stk_full);
    // R6: an unissued warp keeps its PC
    p_hold_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_en |=> $stable(pc_q));
endmodule

// File: rtl/simt_warp_sched.sv
module simt_warp_sched
    import simt_sched_pkg::*;
#(
    parameter int NUM_WARPS   = 4,
    parameter int LANES       = 32,
    parameter int PC_W        = 16,
    parameter int STACK_DEPTH = 4,
    parameter int ID_W        = $clog2(NUM_WARPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_take,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_reconv,
    input  logic             stall_valid,
    input  logic [ID_W-1:0]  stall_warp,
    input  logic             wake_valid,
    input  logic [ID_W-1:0]  wake_warp,
    output logic             issue_valid,
    output logic [ID_W-1:0]  issue_warp,
    output logic [PC_W-1:0]  issue_pc,
    output logic [LANES-1:0] issue_mask,
    output logic             idle
);
    logic [NUM_WARPS-1:0] w_ready;
    logic [PC_W-1:0]      w_pc   [NUM_WARPS];
    logic [LANES-1:0]     w_mask [NUM_WARPS];
    logic                 grant_valid;
    logic [ID_W-1:0]      grant_id;
    sched_st_e            sch_st;

    warp_arbiter #(.NUM_WARPS(NUM_WARPS), .ID_W(ID_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready      (w_ready),
        .grant_valid(grant_valid),
        .grant_id   (grant_id)
    );

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        warp_ctx #(.LANES(LANES), .PC_W(PC_W), .DEPTH(STACK_DEPTH)) u_ctx (
            .clk      (clk),
            .rst_n    (rst_n),
            .issue_en (grant_valid && grant_id == ID_W'(w)),
            .br_valid (br_valid),
            .br_take  (br_take),
            .br_target(br_target),
            .br_reconv(br_reconv),
            .stall_hit(stall_valid && stall_warp == ID_W'(w)),
            .wake_hit (wake_valid && wake_warp == ID_W'(w)),
            .ready    (w_ready[w]),
            .pc       (w_pc[w]),
            .mask     (w_mask[w])
        );
    end

    assign sch_st = grant_valid ? S_ISSUE : S_IDLE;

    always_comb begin
        issue_valid = 1'b0;
        issue_warp  = '0;
        issue_pc    = '0;
        issue_mask  = '0;
        idle        = 1'b0;
        unique case (sch_st)
            S_ISSUE: begin
                issue_valid = 1'b1;
                issue_warp  = grant_id;
                issue_pc    = w_pc[grant_id];
                issue_mask  = w_mask[grant_id];
            end
            S_IDLE: idle = 1'b1;
        endcase
    end

    // R6: idle reflects an empty ready pool
    p_idle_pool_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (w_ready == '0));
endmodule

// File: tb/tb_simt_warp_sched.sv
module tb_simt_warp_sched;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] FULL = 32'hFFFF_FFFF;
    localparam logic [31:0] LO   = 32'h0000_FFFF;
    localparam logic [31:0] HI   = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid;
    logic [31:0] br_take;
    logic [15:0] br_target, br_reconv;
    logic        stall_valid = 1'b0, wake_valid = 1'b0;
    logic [1:0]  stall_warp = '0, wake_warp = '0;
    logic        issue_valid, idle;
    logic [1:0]  issue_warp;
    logic [15:0] issue_pc;
    logic [31:0] issue_mask;
    logic [31:0] div_mask = LO;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simt_warp_sched dut (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_take(br_take),
        .br_target(br_target), .br_reconv(br_reconv),
        .stall_valid(stall_valid), .stall_warp(stall_warp),
        .wake_valid(wake_valid), .wake_warp(wake_warp),
        .issue_valid(issue_valid), .issue_warp(issue_warp),
        .issue_pc(issue_pc), .issue_mask(issue_mask), .idle(idle)
    );

    // instruction tokens answering the issued PC
    always_comb begin
        br_valid = 1'b0; br_take = '0; br_target = '0; br_reconv = '0;
        if (issue_valid) begin
            case (issue_pc)
                16'd2:         begin br_valid = 1'b1; br_take = div_mask; br_target = 16'd10; br_reconv = 16'd20; end
                16'd5, 16'd12: begin br_valid = 1'b1; br_take = FULL; br_target = 16'd20; end
                16'd20:        begin br_valid = 1'b1; br_take = '0;   br_target = 16'd40; end
                16'd21:        begin br_valid = 1'b1; br_take = FULL; br_target = 16'd30; end
                default: ;
            endcase
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_slot(string req, logic v, logic [1:0] w, logic [15:0] pc, logic [31:0] m);
        n_run++;
        if (issue_valid !== v || (v && (issue_warp !== w || issue_pc !== pc || issue_mask !== m))) begin
            n_fail++;
            $display("FAIL %s: got v=%0b w=%0d pc=%0d m=%h, expected v=%0b w=%0d pc=%0d m=%h",
                     req, issue_valid, issue_warp, issue_pc, issue_mask, v, w, pc, m);
        end
    endtask

    task automatic chk_idle(string req, logic exp);
        n_run++;
        if (idle !== exp) begin
            n_fail++;
            $display("FAIL %s: idle got %0b expected %0b", req, idle, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk_slot("R1 reset slot", 1'b1, 2'd0, 16'd0, FULL);
        chk_idle("R1 reset idle", 1'b0);
    endtask

    task automatic t_round_robin();
        for (int k = 1; k <= 3; k++) begin
            step();
            chk_slot("R2 rotation", 1'b1, 2'(k), 16'd0, FULL);
        end
        step();
        chk_slot("R3 pc advance on wrap", 1'b1, 2'd0, 16'd1, FULL);
    endtask

    task automatic t_stall_switch();
        for (int w = 0; w < 4; w++) begin
            stall_valid = 1'b1; stall_warp = 2'(w);
            step();
            stall_valid = 1'b0;
            if (w < 3) chk_slot("R4 switch without gap", 1'b1, 2'(w + 1), 16'd1, FULL);
        end
        chk_slot("R6 no issue when all parked", 1'b0, 2'd0, 16'd0, FULL);
        chk_idle("R6 idle raised", 1'b1);
        step();
        chk_idle("R5 parked warps stay parked", 1'b1);
    endtask

    task automatic t_wake();
        div_mask = LO;
        wake_valid = 1'b1; wake_warp = 2'd0;
        #1;
        chk_idle("R5 wake not effective same cycle", 1'b1);
        step();
        wake_valid = 1'b0;
        chk_slot("R5 woken warp issued next cycle", 1'b1, 2'd0, 16'd2, FULL);
    endtask

    task automatic t_diverge();
        step(); chk_slot("R8 taken path first", 1'b1, 2'd0, 16'd10, LO);
        step(); chk_slot("R8 taken path seq",   1'b1, 2'd0, 16'd11, LO);
        step(); chk_slot("R8 taken path end",   1'b1, 2'd0, 16'd12, LO);
        step(); chk_slot("R9 switch to pending path", 1'b1, 2'd0, 16'd3, HI);
        step(); chk_slot("R9 pending path seq", 1'b1, 2'd0, 16'd4, HI);
        step(); chk_slot("R9 pending path end", 1'b1, 2'd0, 16'd5, HI);
        step(); chk_slot("R10 merged mask at reconvergence", 1'b1, 2'd0, 16'd20, FULL);
        step(); chk_slot("R7 uniform not-taken", 1'b1, 2'd0, 16'd21, FULL);
        step(); chk_slot("R7 uniform taken", 1'b1, 2'd0, 16'd30, FULL);
    endtask

    task automatic t_uniform();
        div_mask = FULL;
        stall_valid = 1'b1; stall_warp = 2'd0;
        wake_valid = 1'b1;  wake_warp = 2'd1;
        step();
        stall_valid = 1'b0; wake_valid = 1'b0;
        chk_slot("R4 stalled warp replaced", 1'b1, 2'd1, 16'd2, FULL);
        step(); chk_slot("R7 uniform divergent-site taken", 1'b1, 2'd1, 16'd10, FULL);
        step(); chk_slot("R7 uniform path seq", 1'b1, 2'd1, 16'd11, FULL);
        step(); chk_slot("R7 uniform path end", 1'b1, 2'd1, 16'd12, FULL);
        step(); chk_slot("R7 no pending path run", 1'b1, 2'd1, 16'd20, FULL);
    endtask

    task automatic t_rr_pair();
        wake_valid = 1'b1; wake_warp = 2'd2;
        step();
        wake_valid = 1'b0;
        chk_slot("R2 next ready after last", 1'b1, 2'd2, 16'd2, FULL);
        step(); chk_slot("R2 alternate back", 1'b1, 2'd1, 16'd21, FULL);
        step(); chk_slot("R2 alternate again", 1'b1, 2'd2, 16'd10, FULL);
        step(); chk_slot("R2 alternate pc", 1'b1, 2'd1, 16'd30, FULL);
        stall_valid = 1'b1; stall_warp = 2'd3;
        wake_valid = 1'b1;  wake_warp = 2'd3;
        step();
        stall_valid = 1'b0; wake_valid = 1'b0;
        chk_slot("R5 pair after stall+wake", 1'b1, 2'd2, 16'd11, FULL);
        step(); chk_slot("R5 stall beats wake", 1'b1, 2'd1, 16'd31, FULL);
    endtask

    initial begin
        t_reset();
        t_round_robin();
        t_stall_switch();
        t_wake();
        t_diverge();
        t_uniform();
        t_rr_pair();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule